// File: doc/BRIEF.md
# Display Event Interrupt Status Unit

This block gathers single-cycle event pulses from a display controller into a sticky raw status register. It forms a masked status as raw AND enable, and drives one level interrupt line toward the processor. Software changes the enable mask only through two write-one ports: one sets mask bits and one clears them. It acknowledges events by writing ones to the masked-status address. An explicit end-of-interrupt (EOI) write re-arms the interrupt line.

The line is controlled by a three-state machine:

- `ST_ARMED`: line low, waiting for a pending masked bit.
- `ST_LATCHED`: line high.
- `ST_SPENT`: line low. Every masked bit has been cleared, but no EOI has arrived yet.

The transitions are:

- `ARMED->LATCHED` when the masked status is non-zero.
- `LATCHED->ARMED` on an EOI write.
- `LATCHED->SPENT` when the masked status becomes empty without an EOI.
- `SPENT->ARMED` on an EOI write.

Until the handler signals EOI, new events cannot raise a second edge. After an EOI, anything still pending raises a fresh edge.

The event positions are:

| Bit | Event |
|---|---|
| 0 | frame finished |
| 1 | raster finished |
| 2 | sync lost |
| 3 | bias-count |
| 5 | FIFO underflow |
| 6 | palette load |
| 8 | buffer-0 end of frame |
| 9 | buffer-1 end of frame |

Positions 4 and 7 are not implemented.

Top module: `intr_status_unit`

## Requirements
- R1: After reset, the raw status, the enable mask and `irq_o` are all zero.
- R2: An `evt_i` pulse on a live bit (0,1,2,3,5,6,8,9) sets that raw bit at the next clock edge, where it stays until cleared. Reading address 0 returns the raw status in bits 9:0.
- R3: Bit positions 4, 7 and 10 and above always read zero, and events or writes on those positions have no effect.
- R4: Reading address 1 returns raw AND enable.
- R5: A write to address 1 clears each raw bit whose data bit is one and leaves the others unchanged. A write to address 0 changes nothing.
- R6: When an event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R7: A write to address 2 sets each enable bit whose data bit is one and leaves the other bits unchanged. Reads of address 2 or 3 return the enable mask.
- R8: A write to address 3 clears each enable bit whose data bit is one and leaves the other bits unchanged.
- R9: In `ST_ARMED`, a non-zero masked status at a clock edge drives `irq_o` high from that edge on. `irq_o` never rises unless the masked status was non-zero in the cycle before.
- R10: In `ST_LATCHED`, `irq_o` stays high until an EOI arrives or the masked status becomes empty. In the latter case the unit enters `ST_SPENT`, where `irq_o` stays low whatever events arrive, until an EOI.
- R11: A write to address 4 (any data) in `ST_LATCHED` or `ST_SPENT` returns the unit to `ST_ARMED` with `irq_o` low for one cycle. If a masked bit is still pending, `irq_o` rises again one cycle later.
- R12: An EOI write in `ST_ARMED` has no effect. Reads of address 4 through 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 10 | Event pulses, one per status position |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
Register writes and events take effect at the next clock edge. Read data is combinational, so the bench samples it 1 ns after it drives the address, away from any edge.

`irq_o` comes from the state register, so it lags the masked status by one edge. An event therefore shows on the line two edges after it is presented, and an EOI drops the line at the first edge.

A behavioural model in the bench advances at every rising edge from the same inputs. At every falling edge the bench compares `irq_o` against the model, so each of these one- and two-edge latencies is checked in the cycle where it falls due.

// File: rtl/isu_pkg.sv
package isu_pkg;
    localparam int NSRC = 10;
    localparam int AW   = 3;

    // live status positions: 0,1,2,3,5,6,8,9
    localparam logic [NSRC-1:0] SRC_LIVE = 10'b11_0110_1111;

    localparam logic [AW-1:0] A_RAW   = 3'd0;
    localparam logic [AW-1:0] A_MSK   = 3'd1;
    localparam logic [AW-1:0] A_ENSET = 3'd2;
    localparam logic [AW-1:0] A_ENCLR = 3'd3;
    localparam logic [AW-1:0] A_EOI   = 3'd4;

    typedef enum logic [1:0] {
        ST_ARMED   = 2'd0,
        ST_LATCHED = 2'd1,
        ST_SPENT   = 2'd2
    } irq_state_e;
endpackage

// File: rtl/isu_event_bank.sv
module isu_event_bank #(
    parameter int               NSRC = 10,
    parameter logic [NSRC-1:0]  LIVE = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt,
    input  logic [NSRC-1:0] clr_vec,
    input  logic [NSRC-1:0] en_set,
    input  logic [NSRC-1:0] en_clr,
    output logic [NSRC-1:0] raw,
    output logic [NSRC-1:0] en
);
    logic unused_dead;
    assign unused_dead = ^(evt & ~LIVE) ^ ^(clr_vec & ~LIVE)
                       ^ ^(en_set & ~LIVE) ^ ^(en_clr & ~LIVE);

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        if (LIVE[i]) begin : g_live
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    raw[i] <= 1'b0;
                    en[i]  <= 1'b0;
                end else begin
                    // event has priority over a clear in the same cycle
                    raw[i] <= evt[i] | (raw[i] & ~clr_vec[i]);
                    en[i]  <= en_set[i] | (en[i] & ~en_clr[i]);
                end
            end
        end else begin : g_dead
            assign raw[i] = 1'b0;
            assign en[i]  = 1'b0;
        end
    end

    // R2
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt & LIVE)) |=> ((raw & $past(evt & LIVE)) == $past(evt & LIVE)));
    // R6
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt & clr_vec & LIVE)) |=> ((raw & $past(evt & clr_vec & LIVE)) == $past(evt & clr_vec & LIVE)));
    // R5
    clr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_vec & ~evt)) |=> ((raw & $past(clr_vec & ~evt)) == '0));
    // R7
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(en_set & LIVE)) |=> ((en & $past(en_set & LIVE)) == $past(en_set & LIVE)));
    // R8
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|en_clr && !(|en_set)) |=> ((en & $past(en_clr)) == '0));
    // R7
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|en_set) && !(|en_clr)) |=> $stable(en));
endmodule

// File: rtl/isu_reg_port.sv
module isu_reg_port #(
    parameter int NSRC = 10,
    parameter int AW   = 3,
    parameter int DW   = 32
) (
    input  logic            reg_we,
    input  logic [AW-1:0]   reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    input  logic [NSRC-1:0] raw,
    input  logic [NSRC-1:0] en,
    output logic [NSRC-1:0] clr_vec,
    output logic [NSRC-1:0] en_set,
    output logic [NSRC-1:0] en_clr,
    output logic            eoi,
    output logic [DW-1:0]   reg_rdata
);
    import isu_pkg::*;

    logic [NSRC-1:0] wbits;
    logic            unused_hi;
    assign wbits     = reg_wdata[NSRC-1:0];
    assign unused_hi = ^reg_wdata[DW-1:NSRC];

    always_comb begin
        clr_vec = '0;
        en_set  = '0;
        en_clr  = '0;
        eoi     = 1'b0;
        if (reg_we) begin
            unique case (reg_addr)
                A_MSK:   clr_vec = wbits;
                A_ENSET: en_set  = wbits;
                A_ENCLR: en_clr  = wbits;
                A_EOI:   eoi     = 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_RAW:   reg_rdata[NSRC-1:0] = raw;
            A_MSK:   reg_rdata[NSRC-1:0] = raw & en;
            A_ENSET,
            A_ENCLR: reg_rdata[NSRC-1:0] = en;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/isu_irq_fsm.sv
module isu_irq_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic eoi,
    output logic irq_o
);
    import isu_pkg::*;

    irq_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_ARMED;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ARMED:   if (pending) state_nx = ST_LATCHED;
            ST_LATCHED: begin
                if (eoi)           state_nx = ST_ARMED;
                else if (!pending) state_nx = ST_SPENT;
            end
            ST_SPENT:   if (eoi) state_nx = ST_ARMED;
            default:    state_nx = ST_ARMED;
        endcase
    end

    always_comb begin
        unique case (state)
            ST_LATCHED: irq_o = 1'b1;
            default:    irq_o = 1'b0;
        endcase
    end

    // R11
    eoi_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && state == ST_LATCHED) |=> !irq_o);
    // R10
    spent_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SPENT && !eoi) |=> !irq_o);
    // R9
    rise_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(pending));
    // R12
    armed_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && eoi && !pending) |=> !irq_o);
endmodule

// File: rtl/intr_status_unit.sv
module intr_status_unit #(
    parameter int DW = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [isu_pkg::NSRC-1:0]    evt_i,
    input  logic                        reg_we,
    input  logic [isu_pkg::AW-1:0]      reg_addr,
    input  logic [DW-1:0]               reg_wdata,
    output logic [DW-1:0]               reg_rdata,
    output logic                        irq_o
);
    import isu_pkg::*;

    logic [NSRC-1:0] raw, en, clr_vec, en_set, en_clr;
    logic            eoi;

    isu_reg_port #(.NSRC(NSRC), .AW(AW), .DW(DW)) u_port (
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .raw       (raw),
        .en        (en),
        .clr_vec   (clr_vec),
        .en_set    (en_set),
        .en_clr    (en_clr),
        .eoi       (eoi),
        .reg_rdata (reg_rdata)
    );

    isu_event_bank #(.NSRC(NSRC), .LIVE(SRC_LIVE)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt_i),
        .clr_vec (clr_vec),
        .en_set  (en_set),
        .en_clr  (en_clr),
        .raw     (raw),
        .en      (en)
    );

    isu_irq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (|(raw & en)),
        .eoi     (eoi),
        .irq_o   (irq_o)
    );
endmodule

// File: tb/intr_status_unit_bench.sv
module intr_status_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  evt_i = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state
    int m_raw = 0;
    int m_en = 0;
    int m_st = 0;   // 0 armed, 1 latched, 2 spent
    localparam int LIVE = 'h36F;

    always #10 clk = ~clk;

    intr_status_unit u_intr_status_unit (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    always @(posedge clk) begin
        int nraw, nen, msk;
        if (!rst_n) begin
            m_raw = 0; m_en = 0; m_st = 0;
        end else begin
            msk  = m_raw & m_en;
            nraw = m_raw;
            nen  = m_en;
            if (reg_we && reg_addr == 1) nraw = nraw & ~int'(reg_wdata[9:0]);
            nraw = (nraw | int'(evt_i)) & LIVE;
            if (reg_we && reg_addr == 2) nen = nen | int'(reg_wdata[9:0]);
            if (reg_we && reg_addr == 3) nen = nen & ~int'(reg_wdata[9:0]);
            nen = nen & LIVE;
            case (m_st)
                0: if (msk != 0) m_st = 1;
                1: if (reg_we && reg_addr == 4) m_st = 0;
                   else if (msk == 0) m_st = 2;
                default: if (reg_we && reg_addr == 4) m_st = 0;
            endcase
            m_raw = nraw; m_en = nen;
        end
    end

    function automatic int model_read(input int a);
        case (a)
            0: return m_raw;
            1: return m_raw & m_en;
            2, 3: return m_en;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done)
            check("R9 R10 R11 irq_o", int'(irq_o), (m_st == 1) ? 1 : 0);
    end

    task automatic step(input logic [9:0] e, input bit w, input int a, input int d);
        evt_i = e; reg_we = w; reg_addr = 3'(a); reg_wdata = 32'(d);
        @(negedge clk);
        evt_i = '0; reg_we = 1'b0;
    endtask

    task automatic rd(input int a, input string tag);
        evt_i = '0; reg_we = 1'b0; reg_addr = 3'(a);
        #1;
        check(tag, int'(reg_rdata), model_read(a));
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int lf;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        reg_addr = 0; #1;
        check("R1 raw", int'(reg_rdata), 0);
        check("R1 irq", int'(irq_o), 0);
        rd(2, "R1 enable");
        // R2 event sets raw with mask off
        step(10'h001, 0, 0, 0);
        rd(0, "R2 raw frame bit");
        check("R2 literal", int'(reg_rdata), 1);
        rd(1, "R4 masked empty");
        // R3 dead positions
        step(10'h090, 0, 0, 0);
        rd(0, "R3 dead events");
        step(10'h000, 1, 2, 'hFFFF_FC90);
        rd(2, "R3 dead enables");
        // R5 write to raw address ignored
        step(10'h000, 1, 0, 'h3FF);
        rd(0, "R5 raw write ignored");
        // R7 enable set -> R9 interrupt
        step(10'h000, 1, 2, 'h101);
        rd(3, "R7 enable read");
        rd(1, "R4 masked");
        rd(0, "R9 wait");
        // R11 EOI while pending -> reassert
        step(10'h000, 1, 4, 0);
        check("R11 low after eoi", int'(irq_o), 0);
        @(negedge clk);
        check("R11 reassert", int'(irq_o), 1);
        // R5 clear masked -> R10 spent
        step(10'h000, 1, 1, 'h001);
        rd(0, "R5 cleared");
        @(negedge clk);
        check("R10 spent low", int'(irq_o), 0);
        step(10'h100, 0, 0, 0);
        @(negedge clk); @(negedge clk);
        check("R10 spent ignores event", int'(irq_o), 0);
        step(10'h000, 1, 4, 0);
        @(negedge clk);
        check("R11 rearm pending", int'(irq_o), 1);
        // R6 event and clear together
        step(10'h100, 1, 1, 'h100);
        rd(0, "R6 event wins");
        // R8 enable clear
        step(10'h000, 1, 3, 'h100);
        rd(2, "R8 enable cleared");
        step(10'h000, 1, 4, 0);
        @(negedge clk);
        // R12 EOI while armed
        step(10'h000, 1, 4, 'h3FF);
        rd(0, "R12 eoi armed");
        rd(4, "R12 read eoi addr");
        rd(7, "R12 read high addr");
        // mixed traffic
        lf = 'h1ACE5;
        for (int i = 0; i < 3000; i++) begin
            lf = (lf >> 1) ^ ((lf & 1) ? 'hB4BCD35C : 0);
            evt_i = (lf[3:0] == 0) ? lf[13:4] : '0;
            reg_we = lf[19] & lf[18];
            reg_addr = 3'(lf[23:21] % 6);
            reg_wdata = {lf[31:12], lf[11:0]};
            if (!reg_we) begin
                #1;
                check("R2 R4 R7 mixed read", int'(reg_rdata), model_read(int'(reg_addr)));
            end
            @(negedge clk);
        end
        evt_i = '0; reg_we = 1'b0;
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule